// File: doc/BRIEF.md
# Looping Multi-Frame LED Animation Sequencer

This block holds eight lighting frames in a byte-addressed store and, once placed in the automatic mode, shows them one after another in a continuous loop. Each frame carries the on/off pattern and the brightness duty value for all sixteen output channels. A host loads the store and the control fields through a plain write port: an address, a data byte and a one-cycle write strobe. The active frame's channel enables and duty bytes go straight to a downstream PWM stage.

Frame stepping is paced by a delay counter. The counter counts a 1 ms tick, which a prescaler derives from the system clock. The time between steps is a power of two times 32 ms, and playback begins at a frame that the host selects.

Two sequencers can be kept in lock-step. The master drives a sync clock whose rising edge marks each of its frame steps. A block set to the slave role ignores its own timer and steps once per rising edge seen on its sync input.

Top module: `led_frame_seq`

## Requirements
- R1: After reset the frame index is 0, every channel enable and duty output is 0, the sync output is low and the mode is 00 (not playing).
- R2: Frame k (0 to 7) occupies byte addresses 0x20+18k to 0x31+18k. Byte 0 of a frame drives the enables of channels 15..8 (bit i to channel 8+i). Byte 1 drives the enables of channels 7..0 (bit i to channel i), with 1 meaning on. Byte 2+j is the duty of channel j. While playing, the outputs show the frame selected by the frame index.
- R3: Playback runs only while bits 6:5 of the register at 0x00 equal 01. In any other mode, all enable and duty outputs are 0 and the frame index holds its value.
- R4: On the write that moves the mode into 01, the frame index loads the start code (bits 7:5 at 0xB7, code c meaning frame index c) one cycle after the write edge. The delay count restarts, so the first step comes 32·2^d·TICK_DIV cycles after that load.
- R5: Between steps the block waits 32·2^d ticks of TICK_DIV clock cycles each, where d is bits 7:5 at 0xB6.
- R6: Each step raises the frame index by one, and index 7 wraps to 0.
- R7: In master role (bit 7 at 0x03 equal to 0), the sync output goes high on the same edge as each step. It returns low after half the step interval and stays low when not playing.
- R8: In slave role (bit 7 at 0x03 equal to 1), the internal timer causes no step and the sync output stays low. Each rising edge on the sync input causes exactly one step, visible on the third clock edge after the input changes. Falling edges cause no step.
- R9: A host write to a frame byte whose capture edge coincides with a step edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Write data |
| sync_in | input | 1 | Step clock taken in slave role |
| sync_out | output | 1 | Step clock driven in master role |
| frame_idx | output | 3 | Index of the frame on show (0 = first) |
| chan_en | output | 16 | On/off state per channel |
| chan_duty | output | 128 | Duty byte per channel, channel j at bits 8j+7:8j |

## Verification
A frame step and a host write into the frame store can fall on the same clock edge. The case that matters is a write aimed at the frame about to become active. The bench counts cycles from the mode-entry write, so it knows the exact step edge, and it drives the write so that the write is captured on that edge. Right after the edge, the bench requires both the new frame index and the newly written duty byte on the outputs. Mode entry and a pending step are also made to meet: each run re-enters the mode in mid-period and checks that the timer restarts from zero.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam logic [7:0] ADDR_CFG   = 8'h00;
  localparam logic [7:0] ADDR_FX    = 8'h03;
  localparam logic [7:0] ADDR_DLY   = 8'hB6;
  localparam logic [7:0] ADDR_START = 8'hB7;
  localparam int         FRAME_BASE = 32'h20;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_AUTO   = 2'b01,
    MODE_AUDIO  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic       slave;
    logic [2:0] dly_code;
    logic [2:0] start_code;
  } ctrl_t;

endpackage

// File: rtl/lfs_regs.sv
module lfs_regs
  import lfs_pkg::*;
#(
  parameter int NFRAMES     = 8,
  parameter int FRAME_BYTES = 18
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [7:0]                        wr_addr,
  input  logic [7:0]                        wr_data,
  output ctrl_t                             ctrl_o,
  output logic [NFRAMES*FRAME_BYTES*8-1:0]  mem_o
);

  localparam int NBYTES = NFRAMES * FRAME_BYTES;

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CFG:   ctrl_d.mode       = mode_e'(wr_data[6:5]);
        ADDR_FX:    ctrl_d.slave      = wr_data[7];
        ADDR_DLY:   ctrl_d.dly_code   = wr_data[7:5];
        ADDR_START: ctrl_d.start_code = wr_data[7:5];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.mode       <= MODE_STATIC;
      ctrl_q.slave      <= 1'b0;
      ctrl_q.dly_code   <= 3'd0;
      ctrl_q.start_code <= 3'd0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [7:0] BYTE_ADDR = 8'(FRAME_BASE + i);
    logic       hit;
    logic [7:0] byte_q;
    assign hit = wr_en && (wr_addr == BYTE_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= 8'h00;
      else if (hit) byte_q <= wr_data;
    end
    assign mem_o[i*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/lfs_tick.sv
module lfs_tick #(
  parameter int TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick_o
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] pre_q, pre_d;

  always_comb begin
    if (clear)              pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = !clear && (pre_q == LAST);

  // R5
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);

endmodule

// File: rtl/lfs_timer.sv
module lfs_timer #(
  parameter int BASE_TICKS = 32,
  parameter int NCODES     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       tick,
  input  logic [2:0] dly_code,
  output logic       adv_o,
  output logic       sync_o
);

  localparam int LIM_W = $clog2(BASE_TICKS << (NCODES - 1)) + 1;

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] limit, half;
  logic             sync_q, sync_d;
  logic             idle;

  assign limit = LIM_W'(BASE_TICKS) << dly_code;
  assign half  = limit >> 1;
  assign idle  = restart || !run;

  always_comb begin
    adv_o  = 1'b0;
    cnt_d  = cnt_q;
    sync_d = sync_q;
    if (idle) begin
      cnt_d  = '0;
      sync_d = 1'b0;
    end else if (tick) begin
      if (cnt_q >= limit - 1'b1) begin
        adv_o  = 1'b1;
        cnt_d  = '0;
        sync_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == half - 1'b1) sync_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;

  // R5
  adv_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> tick);

  // R7
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> sync_o);

  // R7
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sync_o);

endmodule

// File: rtl/lfs_sync.sv
module lfs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic rise_o
);

  logic [2:0] s_q, s_d;

  always_comb s_d = {s_q[1:0], sync_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= 3'b000;
    else        s_q <= s_d;
  end

  assign rise_o = s_q[1] & ~s_q[2];

  // R8
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import lfs_pkg::*;
#(
  parameter int NFRAMES    = 8,
  parameter int NCH        = 16,
  parameter int TICK_DIV   = 200000,
  parameter int BASE_TICKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             sync_in,
  output logic             sync_out,
  output logic [2:0]       frame_idx,
  output logic [NCH-1:0]   chan_en,
  output logic [NCH*8-1:0] chan_duty
);

  localparam int EN_BYTES    = NCH / 8;
  localparam int FRAME_BYTES = EN_BYTES + NCH;
  localparam int FRAME_W     = FRAME_BYTES * 8;
  localparam logic [2:0] LAST = 3'(NFRAMES - 1);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ctrl_t                      ctrl;
  logic [NFRAMES*FRAME_W-1:0] mem;
  logic                       playing, play_q, play_rise;
  logic                       run_master, tick, m_adv, s_rise, step;
  logic [2:0]                 idx_q, idx_d;

  lfs_regs #(.NFRAMES(NFRAMES), .FRAME_BYTES(FRAME_BYTES)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .mem_o(mem)
  );

  assign playing    = (ctrl.mode == MODE_AUTO);
  assign play_rise  = playing && !play_q;
  assign run_master = playing && !ctrl.slave;

  lfs_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_sync_n), .clear(play_rise || !run_master),
    .tick_o(tick)
  );

  lfs_timer #(.BASE_TICKS(BASE_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_sync_n), .run(run_master), .restart(play_rise),
    .tick(tick), .dly_code(ctrl.dly_code), .adv_o(m_adv), .sync_o(sync_out)
  );

  lfs_sync sync_i (
    .clk(clk), .rst_n(rst_sync_n), .sync_in(sync_in), .rise_o(s_rise)
  );

  assign step = !play_rise && (m_adv || (playing && ctrl.slave && s_rise));

  always_comb begin
    idx_d = idx_q;
    if (play_rise)  idx_d = ctrl.start_code;
    else if (step)  idx_d = (idx_q == LAST) ? 3'd0 : idx_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q  <= 3'd0;
      play_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      play_q <= playing;
    end
  end

  assign frame_idx = idx_q;

  logic [FRAME_W-1:0] frame_vec [NFRAMES];
  logic [FRAME_W-1:0] active;

  for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
    assign frame_vec[f] = mem[f*FRAME_W +: FRAME_W];
  end

  assign active = frame_vec[idx_q];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign chan_en[c]          = playing & active[(EN_BYTES - 1 - c/8)*8 + c%8];
    assign chan_duty[c*8 +: 8] = playing ? active[(EN_BYTES + c)*8 +: 8] : 8'h00;
  end

  // R6
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(play_q) && !$stable(idx_q)) |->
      (idx_q == (($past(idx_q) == LAST) ? 3'd0 : $past(idx_q) + 3'd1)));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !playing |=> $stable(idx_q));

endmodule

// File: tb/led_frame_seq_tb_top.sv
`timescale 1ns/1ps
module led_frame_seq_tb_top;

  localparam int DIV = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_addr, wr_data;
  logic         sync_in;
  logic         sync_out;
  logic [2:0]   frame_idx;
  logic [15:0]  chan_en;
  logic [127:0] chan_duty;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mirror [144];

  always #2.5 clk = ~clk;

  led_frame_seq #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out),
    .frame_idx(frame_idx), .chan_en(chan_en), .chan_duty(chan_duty)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'h20 && a <= 8'hAF) mirror[a - 8'h20] = d;
  endtask

  function automatic logic [15:0] exp_en(input int f);
    logic [15:0] v;
    for (int c = 0; c < 16; c++) v[c] = mirror[f*18 + (1 - c/8)][c%8];
    return v;
  endfunction

  function automatic logic [127:0] exp_duty(input int f);
    logic [127:0] v;
    for (int c = 0; c < 16; c++) v[c*8 +: 8] = mirror[f*18 + 2 + c];
    return v;
  endfunction

  function automatic int ld(input int code);
    return (32 << code) * DIV;
  endfunction

  task automatic check_frame(input string req);
    chk(req, 128'(chan_en), 128'(exp_en(int'(frame_idx))));
    chk(req, chan_duty, exp_duty(int'(frame_idx)));
  endtask

  task automatic wait_change(input int n0, output int n, output logic prev_sync);
    logic [2:0] cur;
    cur = frame_idx;
    n = n0;
    prev_sync = sync_out;
    forever begin
      @(negedge clk);
      n++;
      if (frame_idx != cur || n > 20000) break;
      prev_sync = sync_out;
    end
  endtask

  task automatic enter(input int start, input int code);
    wr(8'h00, 8'h80);
    wr(8'hB7, 8'(start << 5));
    wr(8'hB6, 8'(code << 5));
    wr(8'h00, 8'hA0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    logic ps;
    logic [2:0] hold;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_in = 1'b0;
    for (int i = 0; i < 144; i++) mirror[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 idx", 128'(frame_idx), 128'd0);
    chk("R1 en", 128'(chan_en), 128'd0);
    chk("R1 duty", chan_duty, 128'd0);
    chk("R1 sync", 128'(sync_out), 128'd0);

    for (int f = 0; f < 8; f++)
      for (int b = 0; b < 18; b++)
        wr(8'(32 + f*18 + b), 8'((f*37 + b*11 + 5) & 255));

    // R3 mode 00 keeps outputs dark
    chk("R3 en idle", 128'(chan_en), 128'd0);
    chk("R3 duty idle", chan_duty, 128'd0);

    // R4 R5 R6 R7 R2: every start frame, code 0
    for (int s = 0; s < 8; s++) begin
      enter(s, 0);
      chk("R4 start", 128'(frame_idx), 128'(s));
      check_frame("R2 start");
      for (int k = 0; k < 9; k++) begin
        wait_change((k == 0) ? 1 : 0, n, ps);
        chk("R5 period", 128'(n), 128'(((k == 0) ? 1 : 0) + ld(0)));
        chk("R6 order", 128'(frame_idx), 128'((s + k + 1) % 8));
        chk("R7 sync before", 128'(ps), 128'd0);
        chk("R7 sync at step", 128'(sync_out), 128'd1);
        check_frame("R2 step");
      end
    end

    // R5 every delay code
    for (int code = 0; code < 8; code++) begin
      enter(5, code);
      wait_change(1, n, ps);
      chk("R5 first", 128'(n), 128'(1 + ld(code)));
      wait_change(0, n, ps);
      chk("R5 next", 128'(n), 128'(ld(code)));
      chk("R6 wrap", 128'(frame_idx), 128'd7);
    end

    // R3 leaving the mode freezes index and blanks outputs
    enter(3, 0);
    repeat (10) @(negedge clk);
    wr(8'h00, 8'hC0);
    hold = frame_idx;
    repeat (2 * ld(0) + 7) @(negedge clk);
    chk("R3 hold audio", 128'(frame_idx), 128'(hold));
    chk("R3 en off", 128'(chan_en), 128'd0);
    chk("R3 duty off", chan_duty, 128'd0);
    chk("R7 sync off", 128'(sync_out), 128'd0);

    // R9 write lands on the step edge
    enter(2, 0);
    n = 1;
    while (n < ld(0)) begin @(negedge clk); n++; end
    chk("R9 pre", 128'(frame_idx), 128'd2);
    wr_en = 1'b1; wr_addr = 8'(32 + 3*18 + 2); wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    mirror[3*18 + 2] = 8'h5A;
    chk("R9 idx", 128'(frame_idx), 128'd3);
    chk("R9 duty", 128'(chan_duty[7:0]), 128'h5A);
    check_frame("R9 frame");

    // R8 slave role
    wr(8'h03, 8'h80);
    enter(1, 0);
    repeat (2 * ld(0) + 5) @(negedge clk);
    chk("R8 no self step", 128'(frame_idx), 128'd1);
    chk("R8 sync low", 128'(sync_out), 128'd0);
    for (int p = 0; p < 10; p++) begin
      hold = frame_idx;
      sync_in = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 not yet", 128'(frame_idx), 128'(hold));
      @(negedge clk);
      chk("R8 step", 128'(frame_idx), 128'((int'(hold) + 1) % 8));
      check_frame("R2 slave");
      hold = frame_idx;
      sync_in = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 fall ignored", 128'(frame_idx), 128'(hold));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule